// File: doc/BRIEF.md
# Calendar Time Counter with Alarm

This block holds the running time of day and the calendar date: seconds, minutes, hours, day of week, day of month, month and a two-digit year. Each pulse on the one-second tick input advances the time by one second when the oscillator control field permits it. Months have their proper lengths, and February gains a day in years divisible by four. Software reads and writes the time, date and alarm registers through a small select/data port. Mode inputs choose BCD or binary encoding and 12-hour or 24-hour presentation of the hour.

Every accepted tick starts a two-phase update. The internal counters step at once and the update-in-progress flag rises. After a fixed window of `UIP_CYCLES` clocks the visible registers are refreshed from the counters, the alarm is compared, and the update-ended and alarm flags are posted to a sticky status byte that drives the interrupt line. A hold input freezes the visible registers so that software can load a consistent new time. Releasing the hold copies the registers into the counters.

Top module: `rtc_calendar`

## Requirements
- R1: A tick is accepted only when `osc_ctl` equals 3'b010 and no update window is open. A tick at any other time changes no register, raises no flag and does not assert `uip`.
- R2: An accepted tick with `set_mode` low asserts `uip` from the next clock for exactly `UIP_CYCLES` cycles. During that window the time registers keep their old values, and the new values are readable once `uip` has fallen.
- R3: With `bin_mode` high the time, date and alarm registers are plain binary. With it low they are BCD, with the tens digit in bits [7:4] and the units digit in bits [3:0].
- R4: With `h24_mode` high the hour register holds 0 to 23. With it low it holds the hour mod 12 in bits [6:0], and bit 7 is set for hours 12 to 23. A 12-hour value written with bit 7 set means that hour plus 12.
- R5: Seconds wrap to 0 and carry when they reach 59 or more. Minutes wrap and carry at 59 or more, and hours wrap and carry at 23 or more. Out-of-range loaded values therefore roll over at the next tick.
- R6: On a day change the day of week counts 0 to 6 and then returns to 0.
- R7: On a day change the day of month wraps to 1 after the month's last day. Month lengths are 31,28,31,30,31,30,31,31,30,31,30,31, with February 29 when the year is divisible by 4. Month 12 wraps to 1 and increments the year, and year 99 wraps to 0.
- R8: While `set_mode` is high, writes do not change the running time, updates do not refresh the registers and `uip` stays low. When `set_mode` falls, the time is reloaded from the registers.
- R9: A write to a time or date register while `set_mode` is low takes effect in the running time before the next tick.
- R10: At the end of an update with `alarm_en` high, each alarm field (seconds, minutes, hours) that has bits [7:6] = 11 or whose decoded value equals the current value counts as a match. If all three match, status bits 7 and 5 are set (0xA0). With `alarm_en` low no alarm flag is set.
- R11: At the end of every update with `upd_en` high, status bits 7 and 4 are set (0x90).
- R12: Status bits stay set until a `flag_clr` pulse clears them all. `irq` follows status bit 7.
- R13: Select codes: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 alarm seconds, 8 alarm minutes, 9 alarm hours. Writes to codes 10 to 15 are ignored, and those codes read 0. After reset every register reads 0 except day of month and month, which read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| osc_ctl | input | 3 | Oscillator control; 3'b010 lets time run |
| set_mode | input | 1 | Hold: freeze visible registers for loading |
| bin_mode | input | 1 | 1 binary, 0 BCD register encoding |
| h24_mode | input | 1 | 1 24-hour, 0 12-hour hour encoding |
| alarm_en | input | 1 | Enable alarm flag |
| upd_en | input | 1 | Enable update-ended flag |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 4 | Register select for reads |
| rd_data | output | 8 | Read data (combinational) |
| flag_clr | input | 1 | Clear all status flags |
| status | output | 8 | Sticky flags: bit 7 any, bit 5 alarm, bit 4 update |
| irq | output | 1 | Interrupt request |
| uip | output | 1 | Update in progress |

## Verification
The bench sweeps every month of a leap year, a common year and year 99 in all four encoding and hour-format combinations. It starts both from the last second of the month and from 11:59:59 mid-month. A wrong month-length or leap rule would leave day 29 in February or skip day 31. A bad 12-hour encoding would show noon as 0x12 instead of 0x80 and midnight without a wrapped hour. Directed cases count the `uip` cycles and read a register inside the window, which catches a refresh issued at the tick rather than at window end. Further cases load out-of-range seconds to expose an equality-only rollover, tick during hold to catch refreshes that leak through, and try don't-care and mismatching alarm fields along with flag persistence across updates.

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter int UIP_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [2:0] osc_ctl,
  input  logic       set_mode,
  input  logic       bin_mode,
  input  logic       h24_mode,
  input  logic       alarm_en,
  input  logic       upd_en,
  input  logic       wr_en,
  input  logic [3:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [3:0] rd_sel,
  output logic [7:0] rd_data,
  input  logic       flag_clr,
  output logic [7:0] status,
  output logic       irq,
  output logic       uip
);
  localparam int CW = $clog2(UIP_CYCLES + 1);
  localparam logic [3:0] S_ASEC  = 4'd7;
  localparam logic [3:0] S_AHOUR = 4'd9;

  function automatic logic [7:0] dec(input logic [7:0] v, input logic bin);
    return bin ? v : ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction

  function automatic logic [7:0] enc(input logic [7:0] v, input logic bin);
    return bin ? v : (((v / 8'd10) << 4) | (v % 8'd10));
  endfunction

  function automatic logic [7:0] dec_hour(input logic [7:0] v, input logic bin, input logic h24);
    logic [7:0] h;
    h = dec({1'b0, v[6:0]}, bin);
    if (!h24 && v[7]) h = h + 8'd12;
    return h;
  endfunction

  function automatic logic [7:0] enc_hour(input logic [7:0] h, input logic bin, input logic h24);
    if (h24) return enc(h, bin);
    return (h >= 8'd12 ? 8'h80 : 8'h00) | enc(h % 8'd12, bin);
  endfunction

  logic [7:0] regs [16];
  logic [7:0] t_sec, t_min, t_hour, t_dow, t_mday, t_mon, t_year;
  logic [7:0] n_sec, n_min, n_hour, n_dow, n_mday, n_mon, n_year, dim;
  logic [CW-1:0] cnt;
  logic uip_r, set_q, reload;
  logic [7:0] st;

  wire run     = osc_ctl == 3'b010;
  wire tick_ok = sec_tick && run && cnt == '0;
  wire finish  = cnt == CW'(1);
  wire leap    = t_year[1:0] == 2'b00;

  wire [7:0] d_sec  = dec(regs[0], bin_mode);
  wire [7:0] d_min  = dec(regs[1], bin_mode);
  wire [7:0] d_hour = dec_hour(regs[2], bin_mode, h24_mode);
  wire [7:0] d_dow  = dec(regs[3], bin_mode);
  wire [7:0] d_mday = dec(regs[4], bin_mode);
  wire [7:0] d_mon  = dec(regs[5], bin_mode);
  wire [7:0] d_year = dec(regs[6], bin_mode);

  wire a_sec  = regs[7][7:6] == 2'b11 || dec(regs[7], bin_mode) == t_sec;
  wire a_min  = regs[8][7:6] == 2'b11 || dec(regs[8], bin_mode) == t_min;
  wire a_hour = regs[9][7:6] == 2'b11 || dec(regs[9], bin_mode) == t_hour;
  wire alarm_hit = alarm_en && a_sec && a_min && a_hour;

  assign rd_data = regs[rd_sel];
  assign status  = st;
  assign irq     = st[7];
  assign uip     = uip_r;

  always_comb begin
    case (t_mon)
      8'd2:                     dim = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  dim = 8'd30;
      default:                  dim = 8'd31;
    endcase
    n_sec = t_sec + 8'd1; n_min = t_min; n_hour = t_hour; n_dow = t_dow;
    n_mday = t_mday; n_mon = t_mon; n_year = t_year;
    if (t_sec >= 8'd59) begin
      n_sec = 8'd0;
      n_min = t_min + 8'd1;
      if (t_min >= 8'd59) begin
        n_min  = 8'd0;
        n_hour = t_hour + 8'd1;
        if (t_hour >= 8'd23) begin
          n_hour = 8'd0;
          n_dow  = (t_dow >= 8'd6) ? 8'd0 : t_dow + 8'd1;
          n_mday = t_mday + 8'd1;
          if (t_mday >= dim) begin
            n_mday = 8'd1;
            n_mon  = t_mon + 8'd1;
            if (t_mon >= 8'd12) begin
              n_mon  = 8'd1;
              n_year = (t_year >= 8'd99) ? 8'd0 : t_year + 8'd1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) regs[i] <= 8'h00;
      regs[4] <= 8'h01;
      regs[5] <= 8'h01;
      t_sec <= '0; t_min <= '0; t_hour <= '0; t_dow <= '0;
      t_mday <= 8'd1; t_mon <= 8'd1; t_year <= '0;
      cnt <= '0; uip_r <= 1'b0; set_q <= 1'b0; reload <= 1'b0; st <= '0;
    end else begin
      set_q  <= set_mode;
      reload <= (wr_en && wr_sel < S_ASEC && !set_mode) || (set_q && !set_mode);
      if (reload) begin
        t_sec <= d_sec; t_min <= d_min; t_hour <= d_hour; t_dow <= d_dow;
        t_mday <= d_mday; t_mon <= d_mon; t_year <= d_year;
      end else if (tick_ok) begin
        t_sec <= n_sec; t_min <= n_min; t_hour <= n_hour; t_dow <= n_dow;
        t_mday <= n_mday; t_mon <= n_mon; t_year <= n_year;
      end
      if (tick_ok) begin
        cnt   <= CW'(UIP_CYCLES);
        uip_r <= !set_mode;
      end else if (finish) begin
        cnt   <= '0;
        uip_r <= 1'b0;
        if (!set_mode) begin
          regs[0] <= enc(t_sec, bin_mode);
          regs[1] <= enc(t_min, bin_mode);
          regs[2] <= enc_hour(t_hour, bin_mode, h24_mode);
          regs[3] <= enc(t_dow, bin_mode);
          regs[4] <= enc(t_mday, bin_mode);
          regs[5] <= enc(t_mon, bin_mode);
          regs[6] <= enc(t_year, bin_mode);
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
      if (set_mode) uip_r <= 1'b0;
      st <= (flag_clr ? 8'h00 : st) |
            (finish ? {alarm_hit | upd_en, 1'b0, alarm_hit, upd_en, 4'h0} : 8'h00);
      if (wr_en && wr_sel <= S_AHOUR) regs[wr_sel] <= wr_data;
    end
  end

  AST_NO_TICK_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !run && !reload) |=> $stable(t_sec)); // R1
  AST_UIP_INSIDE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    uip |-> cnt != '0); // R2
  AST_REGS_HOLD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > CW'(1) && !wr_en) |=> $stable(regs[0])); // R2
  AST_SET_BLOCKS_UIP: assert property (@(posedge clk) disable iff (!rst_n)
    set_mode |=> !uip); // R8
  AST_ALARM_AT_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[5]) |-> $past(cnt) == CW'(1)); // R10
  AST_UPDATE_FLAG_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[4]) |-> $past(upd_en)); // R11
endmodule

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
  localparam int UIPC = 8;

  logic clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0;
  logic [2:0] osc_ctl = 3'b010;
  logic set_mode = 1'b0, bin_mode = 1'b0, h24_mode = 1'b1;
  logic alarm_en = 1'b0, upd_en = 1'b0, wr_en = 1'b0, flag_clr = 1'b0;
  logic [3:0] wr_sel = '0, rd_sel = '0;
  logic [7:0] wr_data = '0;
  wire  [7:0] rd_data, status;
  wire        irq, uip;

  int checks = 0, errors = 0;
  int m_sec, m_min, m_hour, m_dow, m_mday, m_mon, m_year;

  always #4 clk = ~clk;

  rtc_calendar #(.UIP_CYCLES(UIPC)) u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .osc_ctl(osc_ctl),
    .set_mode(set_mode), .bin_mode(bin_mode), .h24_mode(h24_mode),
    .alarm_en(alarm_en), .upd_en(upd_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .flag_clr(flag_clr),
    .status(status), .irq(irq), .uip(uip)
  );

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic int enc(int v);
    return bin_mode ? v : (v / 10) * 16 + v % 10;
  endfunction

  function automatic int enc_h(int h);
    if (h24_mode) return enc(h);
    return enc(h % 12) + (h >= 12 ? 128 : 0);
  endfunction

  function automatic int mdays(int m, int y);
    int d = 28 + (m + m / 8) % 2 + 2 % m + 2 * (1 / m);
    if (m == 2 && y % 4 == 0) d++;
    return d;
  endfunction

  task automatic rd(input int sel, output int v);
    rd_sel = sel[3:0];
    #1;
    v = int'(rd_data);
  endtask

  task automatic wr(input int sel, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel[3:0]; wr_data = val[7:0];
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic load_model();
    @(negedge clk) set_mode = 1'b1;
    wr(0, enc(m_sec)); wr(1, enc(m_min)); wr(2, enc_h(m_hour)); wr(3, enc(m_dow));
    wr(4, enc(m_mday)); wr(5, enc(m_mon)); wr(6, enc(m_year));
    @(negedge clk) set_mode = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
    repeat (UIPC + 2) @(negedge clk);
  endtask

  task automatic tick_count(output int n, output int first_sec);
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
    n = 0;
    rd(0, first_sec);
    for (int i = 0; i < UIPC + 4; i++) begin
      if (uip) n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  task automatic model_next();
    m_sec++;
    if (m_sec >= 60) begin
      m_sec = 0; m_min++;
      if (m_min >= 60) begin
        m_min = 0; m_hour++;
        if (m_hour >= 24) begin
          m_hour = 0;
          m_dow = (m_dow + 1) % 7;
          m_mday++;
          if (m_mday > mdays(m_mon, m_year)) begin
            m_mday = 1; m_mon++;
            if (m_mon > 12) begin m_mon = 1; m_year = (m_year + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic check_all(input string ctx);
    int v;
    rd(0, v); check("R3 R5", {ctx, " sec"},  v, enc(m_sec));
    rd(1, v); check("R5",    {ctx, " min"},  v, enc(m_min));
    rd(2, v); check("R4 R5", {ctx, " hour"}, v, enc_h(m_hour));
    rd(3, v); check("R6",    {ctx, " dow"},  v, enc(m_dow));
    rd(4, v); check("R7",    {ctx, " mday"}, v, enc(m_mday));
    rd(5, v); check("R7",    {ctx, " mon"},  v, enc(m_mon));
    rd(6, v); check("R7",    {ctx, " year"}, v, enc(m_year));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    int v, n, s0;
    int yrs[3] = '{0, 1, 99};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset values
    for (int i = 0; i < 10; i++) begin
      rd(i, v);
      check("R13", $sformatf("reset reg %0d", i), v, (i == 4 || i == 5) ? 1 : 0);
    end
    check("R13", "reset uip", uip, 0);
    check("R12", "reset status", status, 0);
    check("R12", "reset irq", irq, 0);

    // R2 window
    bin_mode = 1'b0; h24_mode = 1'b1;
    m_sec = 30; m_min = 20; m_hour = 10; m_dow = 2; m_mday = 14; m_mon = 3; m_year = 24;
    load_model();
    tick_count(n, s0);
    check("R2", "uip cycles", n, UIPC);
    check("R2", "sec inside window", s0, 8'h30);
    rd(0, v); check("R2", "sec after window", v, 8'h31);

    // R1 oscillator gating and busy ticks
    upd_en = 1'b1;
    osc_ctl = 3'b000;
    tick_count(n, s0);
    check("R1", "uip with osc off", n, 0);
    rd(0, v); check("R1", "sec with osc off", v, 8'h31);
    check("R1", "status with osc off", status, 0);
    osc_ctl = 3'b110;
    tick_count(n, s0);
    rd(0, v); check("R1", "sec with osc 110", v, 8'h31);
    osc_ctl = 3'b010; upd_en = 1'b0;
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
    @(negedge clk);
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
    repeat (UIPC + 4) @(negedge clk);
    rd(0, v); check("R1", "tick in window ignored", v, 8'h32);

    // R8 hold mode
    @(negedge clk) set_mode = 1'b1;
    wr(0, 8'h45);
    tick_count(n, s0);
    check("R8", "uip during hold", n, 0);
    rd(0, v); check("R8", "sec not refreshed in hold", v, 8'h45);
    rd(1, v); check("R8", "min unchanged in hold", v, 8'h20);
    @(negedge clk) set_mode = 1'b0;
    repeat (3) @(negedge clk);
    tick();
    rd(0, v); check("R8", "reload after hold", v, 8'h46);

    // R9 direct write
    wr(1, 8'h07);
    tick();
    rd(0, v); check("R9", "sec after direct write", v, 8'h47);
    rd(1, v); check("R9", "min after direct write", v, 8'h07);

    // R5 out-of-range load, binary
    bin_mode = 1'b1;
    m_sec = 75; m_min = 5; m_hour = 3; m_dow = 1; m_mday = 9; m_mon = 4; m_year = 30;
    load_model();
    tick();
    rd(0, v); check("R5", "out-of-range sec wraps", v, 0);
    rd(1, v); check("R5", "out-of-range sec carries", v, 6);

    // R10 R11 R12 flags
    bin_mode = 1'b0;
    m_sec = 14; m_min = 30; m_hour = 8; m_dow = 2; m_mday = 10; m_mon = 5; m_year = 20;
    load_model();
    wr(7, 8'h15); wr(8, 8'h30); wr(9, 8'h08);
    alarm_en = 1'b1;
    tick();
    check("R10", "alarm exact match", status, 8'hA0);
    check("R12", "irq on alarm", irq, 1);
    pulse_clr();
    check("R12", "status cleared", status, 0);
    check("R12", "irq cleared", irq, 0);
    wr(7, 8'hC0); wr(8, 8'hFF);
    tick();
    check("R10", "alarm with dont-care fields", status, 8'hA0);
    pulse_clr();
    wr(9, 8'h09);
    tick();
    check("R10", "alarm hour mismatch", status, 0);
    wr(9, 8'h08);
    alarm_en = 1'b0;
    tick();
    check("R10", "alarm disabled", status, 0);
    upd_en = 1'b1;
    tick();
    check("R11", "update-ended flag", status, 8'h90);
    upd_en = 1'b0;
    tick();
    check("R12", "flags sticky", status, 8'h90);
    pulse_clr();
    alarm_en = 1'b1; upd_en = 1'b1;
    tick();
    check("R11", "alarm plus update", status, 8'hB0);
    pulse_clr();
    alarm_en = 1'b0; upd_en = 1'b0;

    // R13 unused select
    rd(0, s0);
    wr(12, 8'h5A);
    rd(12, v); check("R13", "unused select reads 0", v, 0);
    rd(0, v); check("R13", "unused write leaves sec", v, s0);

    // sweep: formats x years x months
    for (int f = 0; f < 4; f++) begin
      bin_mode = f[0]; h24_mode = f[1];
      for (int yi = 0; yi < 3; yi++) begin
        for (int m = 1; m <= 12; m++) begin
          m_sec = 59; m_min = 59; m_hour = 23; m_dow = m % 7;
          m_mday = mdays(m, yrs[yi]); m_mon = m; m_year = yrs[yi];
          load_model();
          tick();
          model_next();
          check_all($sformatf("fmt%0d y%0d m%0d month-end", f, yrs[yi], m));
          m_sec = 59; m_min = 59; m_hour = 11; m_dow = 6;
          m_mday = 15; m_mon = m; m_year = yrs[yi];
          load_model();
          tick();
          model_next();
          check_all($sformatf("fmt%0d y%0d m%0d noon", f, yrs[yi], m));
        end
      end
    end

    finish_up();
  end
endmodule